// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a system-on-chip. It sits on a simple 16-bit register bus and counts down on a slow tick input, one tick per 10 ms interval. Software controls it only by writing 16-bit key words: one key reloads the countdown, another resumes a stopped timer, and stopping it takes two different keys written back to back to two different registers. Any other value written to a key register is ignored.

When the count runs out, the block raises a system reset pulse and reloads itself at once, so it fires again unless software services it. One tick before that happens, it sets an early-warning event, which can be masked onto an interrupt line or set by software through a force bit. The timeout is recorded in a sticky status word that only a power-on reset clears, so boot code can see why the chip restarted. Enable state and status read back as 16-bit signature words, not single bits. A debug-mode input stops the countdown unless software has set an override bit. The count can be read back, and a flag marks the value as unsettled for a few clocks after each change.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped (offset 0x0C reads 0xDABE), status (0x10) reads 0x0000, irq and wdt_rst are low, and the count equals DEF_TO with bit 15 clear.
- R2: Writing 0xFEED to offset 0x00 loads the count from the timeout register; writing any other value there leaves the count unchanged.
- R3: Writing offset 0x04 stores wdata bits 14:0 as the timeout; reading 0x04 returns them with bit 15 zero.
- R4: While running, each tick lowers the count by one. While stopped, ticks leave it unchanged.
- R5: A tick while running with count 1 (or 0) drives wdt_rst high from the next clock for exactly RST_CYC clocks and reloads the count from the timeout register.
- R6: After an expiry, status reads 0xCFE8. Writing 0xE8B4 to 0x10 returns it to 0x0000, other values do not change it, and it keeps its value through rst_n; only por_n clears it.
- R7: Writing 0x2BAD to 0x08 and then, as the very next bus write, 0xCAFE to 0x0C stops the timer; 0x0C then reads 0xDABE, and 0x0000 while running.
- R8: If any other write falls between the two stop keys, or 0xCAFE reaches 0x0C with no 0x2BAD immediately before it, the timer keeps running.
- R9: Writing 0xACED to 0x1C while stopped makes the timer run again; counting resumes from the held count.
- R10: Offset 0x14 returns the count in bits 14:0, and bit 15 is 1 for SETTLE clocks after any change of the count.
- R11: Event bit 0 at 0x20 sets when a running tick takes the count from 2 to 1; writing 1 to bit 0 of 0x20 clears it, unless a set occurs in the same clock.
- R12: irq is high while event bit 0 and mask bit 0 (0x24) are both 1. Force bit 0 (0x28) holds the event set while it is 1.
- R13: Offset 0x18 reads dbg_mode in bit 1 and the override in bit 0. With dbg_mode high and the override clear, ticks do not change the count; with the override set, counting goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low system reset; clears everything except status |
| por_n | input | 1 | Active-low power-on reset; also clears status |
| tick | input | 1 | One-clock pulse per 10 ms interval |
| dbg_mode | input | 1 | High while the chip is under a debugger |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| irq | output | 1 | Early-warning interrupt |
| wdt_rst | output | 1 | System reset pulse |

## Verification
The bench targets the stop sequence with an unrelated write between the keys and with a lone second key. A design that stored the first key forever would stop anyway. The expiry tick is checked for pulse length, immediate reload and status. A design that let the count reach 0 before firing would fire one tick late and fail the reload compare. It also checks that an acknowledge loses to a held force bit, and that status survives rst_n but not por_n. Random sequences of good and bad feeds, timeout writes and ticks are compared against a bench model of the countdown, with the count read the way software reads it: repeated until the unsettled flag drops.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 15;

  // register offsets; software decodes these, so they are fixed
  localparam logic [ADDR_W-1:0] OFS_FEED    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TIMEOUT = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STOP1   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_STOP2   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_DEBUG   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RESUME  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_EVENT   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_FORCE   = 6'h28;

  // key words and signature codes
  localparam logic [DATA_W-1:0] KEY_FEED    = 16'hFEED;
  localparam logic [DATA_W-1:0] KEY_STOP1   = 16'h2BAD;
  localparam logic [DATA_W-1:0] KEY_STOP2   = 16'hCAFE;
  localparam logic [DATA_W-1:0] KEY_RESUME  = 16'hACED;
  localparam logic [DATA_W-1:0] KEY_CLRSTAT = 16'hE8B4;
  localparam logic [DATA_W-1:0] SIG_STOPPED = 16'hDABE;
  localparam logic [DATA_W-1:0] SIG_RUNNING = 16'h0000;
  localparam logic [DATA_W-1:0] SIG_EXPIRED = 16'hCFE8;
  localparam logic [DATA_W-1:0] SIG_NORMAL  = 16'h0000;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_wr_t;

  // count after one running tick, expiry excluded
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - CNT_W'(1);
  endfunction

  // the tick that takes the count past 1 is the expiring one
  function automatic logic cnt_expires(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  // the tick that lands the count on 1 gives the early warning
  function automatic logic cnt_warns(input logic [CNT_W-1:0] c);
    return c == CNT_W'(2);
  endfunction

  function automatic logic hit(input bus_wr_t w, input logic [ADDR_W-1:0] a,
                               input logic [DATA_W-1:0] k);
    return w.en && (w.addr == a) && (w.data == k);
  endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int               RST_CYC = 4,
  parameter int               SETTLE  = 2,
  parameter logic [CNT_W-1:0] DEF_TO  = 15'd6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             feed,
  input  logic [CNT_W-1:0] to_val,
  output logic [CNT_W-1:0] cnt,
  output logic             unstable,
  output logic             fire,
  output logic             warn,
  output logic             wdt_rst
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int SW = $clog2(SETTLE + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RW-1:0]    rst_cnt_q;
  logic [SW-1:0]    settle_q;
  logic             step;

  always_comb begin
    step  = tick && run;
    fire  = step && !feed && cnt_expires(cnt_q);
    warn  = step && !feed && cnt_warns(cnt_q);
    cnt_d = cnt_q;
    if (feed || fire) cnt_d = to_val;
    else if (step)    cnt_d = cnt_step(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= DEF_TO;
      settle_q  <= '0;
      rst_cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cnt_d != cnt_q)      settle_q <= SW'(SETTLE);
      else if (settle_q != '0) settle_q <= settle_q - SW'(1);
      if (fire)                 rst_cnt_q <= RW'(RST_CYC);
      else if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - RW'(1);
    end
  end

  assign cnt      = cnt_q;
  assign unstable = (settle_q != '0);
  assign wdt_rst  = (rst_cnt_q != '0);

  a_r5_fire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wdt_rst);
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == $past(to_val)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !feed) |=> $stable(cnt));
  a_r10_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> unstable);
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic warn,
  input  logic force_on,
  input  logic ack,
  input  logic mask_on,
  output logic evt,
  output logic irq
);
  logic evt_q;
  logic set;

  assign set = warn || force_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   evt_q <= 1'b0;
    else if (set) evt_q <= 1'b1;
    else if (ack) evt_q <= 1'b0;
  end

  assign evt = evt_q;
  assign irq = evt_q && mask_on;

  a_r11_warn_sets: assert property (@(posedge clk) disable iff (!rst_n)
    warn |=> evt);
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !evt);
  a_r12_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |=> evt);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [CNT_W-1:0] DEF_TO = 15'd6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  bus_wr_t           wr,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              dbg_mode,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              unstable,
  input  logic              evt,
  input  logic              fire,
  output logic [DATA_W-1:0] rdata,
  output logic              feed,
  output logic [CNT_W-1:0]  to_val,
  output logic              run,
  output logic              force_on,
  output logic              mask_on,
  output logic              ack
);
  logic [CNT_W-1:0] to_q;
  logic en_q, armed_q, dbg_en_q, mask_q, force_q, status_q;
  logic stop1_hit, stop2_hit, resume_hit, clr_hit;

  always_comb begin
    feed       = hit(wr, OFS_FEED, KEY_FEED);
    stop1_hit  = hit(wr, OFS_STOP1, KEY_STOP1);
    stop2_hit  = hit(wr, OFS_STOP2, KEY_STOP2) && armed_q;
    resume_hit = hit(wr, OFS_RESUME, KEY_RESUME) && !en_q;
    clr_hit    = hit(wr, OFS_STATUS, KEY_CLRSTAT);
    ack        = wr.en && (wr.addr == OFS_EVENT) && wr.data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q     <= DEF_TO;
      en_q     <= 1'b0;
      armed_q  <= 1'b0;
      dbg_en_q <= 1'b0;
      mask_q   <= 1'b0;
      force_q  <= 1'b0;
    end else begin
      // the first stop key arms only until the next bus write
      if (wr.en) armed_q <= stop1_hit;
      if (stop2_hit)       en_q <= 1'b0;
      else if (resume_hit) en_q <= 1'b1;
      if (wr.en) begin
        case (wr.addr)
          OFS_TIMEOUT: to_q     <= wr.data[CNT_W-1:0];
          OFS_DEBUG:   dbg_en_q <= wr.data[0];
          OFS_MASK:    mask_q   <= wr.data[0];
          OFS_FORCE:   force_q  <= wr.data[0];
          default: ;
        endcase
      end
    end
  end

  // status sits on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       status_q <= 1'b0;
    else if (fire)    status_q <= 1'b1;
    else if (clr_hit) status_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      OFS_TIMEOUT: rdata = {1'b0, to_q};
      OFS_STOP2:   rdata = en_q ? SIG_RUNNING : SIG_STOPPED;
      OFS_STATUS:  rdata = status_q ? SIG_EXPIRED : SIG_NORMAL;
      OFS_COUNT:   rdata = {unstable, cnt};
      OFS_DEBUG:   rdata = {14'b0, dbg_mode, dbg_en_q};
      OFS_EVENT:   rdata = {15'b0, evt};
      OFS_MASK:    rdata = {15'b0, mask_q};
      OFS_FORCE:   rdata = {15'b0, force_q};
      default:     rdata = '0;
    endcase
  end

  assign to_val   = to_q;
  assign run      = en_q && (!dbg_mode || dbg_en_q);
  assign force_on = force_q;
  assign mask_on  = mask_q;

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop2_hit |=> !en_q);
  a_r8_lone_key: assert property (@(posedge clk) disable iff (!rst_n)
    (hit(wr, OFS_STOP2, KEY_STOP2) && !armed_q) |=> $stable(en_q));
  a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
    resume_hit |=> en_q);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!por_n)
    fire |=> status_q);
  a_r13_debug_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !dbg_en_q) |-> !run);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int               RST_CYC = 4,
  parameter int               SETTLE  = 2,
  parameter logic [CNT_W-1:0] DEF_TO  = 15'd6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              tick,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wdt_rst
);
  bus_wr_t          wr;
  logic [CNT_W-1:0] cnt, to_val;
  logic unstable, fire, warn, feed, run, force_on, mask_on, ack, evt;

  assign wr = '{en: wr_en, addr: addr, data: wdata};

  wdt_regs #(.DEF_TO(DEF_TO)) u_regs (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr(wr), .raddr(addr),
    .dbg_mode(dbg_mode), .cnt(cnt), .unstable(unstable), .evt(evt),
    .fire(fire), .rdata(rdata), .feed(feed), .to_val(to_val), .run(run),
    .force_on(force_on), .mask_on(mask_on), .ack(ack)
  );

  wdt_counter #(.RST_CYC(RST_CYC), .SETTLE(SETTLE), .DEF_TO(DEF_TO)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .feed(feed),
    .to_val(to_val), .cnt(cnt), .unstable(unstable), .fire(fire),
    .warn(warn), .wdt_rst(wdt_rst)
  );

  wdt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .warn(warn), .force_on(force_on), .ack(ack),
    .mask_on(mask_on), .evt(evt), .irq(irq)
  );

  a_r12_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt && mask_on));
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int RST_CYC = 4;
  localparam int SETTLE  = 2;
  localparam int DEF_TO  = 6000;

  logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, tick = 1'b0, dbg_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq, wdt_rst;
  int checks = 0, errors = 0;
  int exp_cnt, exp_to;

  always #5 clk = ~clk;

  keyed_watchdog #(.RST_CYC(RST_CYC), .SETTLE(SETTLE), .DEF_TO(15'(DEF_TO))) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .dbg_mode(dbg_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
    .wdt_rst(wdt_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // software-style count read: repeat until the unsettled flag drops
  task automatic rd_count(output int c);
    logic [15:0] d;
    d = 16'h8000;
    for (int i = 0; i < 10 && d[15]; i++) bus_rd(6'h14, d);
    c = int'(d[14:0]);
  endtask

  // one tick; returns wdt_rst as seen one clock later, then lets a pulse end
  task automatic do_tick(output logic rst_seen);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; rst_seen = wdt_rst;
    repeat (RST_CYC + 1) @(negedge clk);
  endtask

  // bench model of one running tick
  function automatic bit model_fires(input int c);
    return c <= 1;
  endfunction
  function automatic int model_next(input int c, input int t);
    return (c <= 1) ? t : c - 1;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic r;
    int c, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    bus_rd(6'h0C, d); chk("R1 stopped sig", d, 16'hDABE);
    bus_rd(6'h10, d); chk("R1 status", d, 0);
    bus_rd(6'h14, d); chk("R1 count", d, DEF_TO);
    chk("R1 irq", irq, 0); chk("R1 wdt_rst", wdt_rst, 0);

    // R3 timeout keeps 15 bits
    bus_wr(6'h04, 16'h8005);
    bus_rd(6'h04, d); chk("R3 timeout", d, 5);
    // R2 feed key and wrong value
    bus_wr(6'h00, 16'hFEED);
    rd_count(c); chk("R2 feed reload", c, 5);
    bus_wr(6'h04, 16'h0009);
    bus_wr(6'h00, 16'h1234);
    rd_count(c); chk("R2 bad feed ignored", c, 5);
    bus_wr(6'h04, 16'h0005);
    // R4 stopped holds
    do_tick(r); rd_count(c); chk("R4 stopped hold", c, 5);
    // R9 resume
    bus_wr(6'h1C, 16'hACED);
    bus_rd(6'h0C, d); chk("R9 running sig", d, 0);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    bus_rd(6'h14, d); chk("R10 unsettled flag", d[15], 1);
    rd_count(c); chk("R4 decrement", c, 4);
    do_tick(r); do_tick(r);
    bus_rd(6'h20, d); chk("R11 no early event", d, 0);
    do_tick(r); rd_count(c); chk("R4 count 1", c, 1);
    bus_rd(6'h20, d); chk("R11 event at 1", d, 1);
    chk("R12 masked irq", irq, 0);
    bus_wr(6'h24, 16'h0001); @(negedge clk); chk("R12 irq", irq, 1);
    bus_wr(6'h20, 16'h0001); bus_rd(6'h20, d); chk("R11 ack", d, 0);
    chk("R12 irq after ack", irq, 0);
    // R5 expiry
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    n = 0;
    for (int i = 0; i < 20 && wdt_rst; i++) begin n++; @(negedge clk); end
    chk("R5 pulse width", n, RST_CYC);
    rd_count(c); chk("R5 reload", c, 5);
    bus_rd(6'h10, d); chk("R6 expired sig", d, 16'hCFE8);
    // R12 force
    bus_wr(6'h28, 16'h0001); bus_rd(6'h20, d); chk("R12 force sets", d, 1);
    bus_wr(6'h20, 16'h0001); bus_rd(6'h20, d); chk("R12 force beats ack", d, 1);
    bus_wr(6'h28, 16'h0000); bus_wr(6'h20, 16'h0001);
    bus_rd(6'h20, d); chk("R11 ack after force", d, 0);
    bus_wr(6'h24, 16'h0000);
    // R6 sticky status
    bus_wr(6'h10, 16'h1111); bus_rd(6'h10, d); chk("R6 bad clear", d, 16'hCFE8);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    bus_rd(6'h10, d); chk("R6 survives rst_n", d, 16'hCFE8);
    bus_rd(6'h0C, d); chk("R1 stopped after rst_n", d, 16'hDABE);
    bus_wr(6'h10, 16'hE8B4); bus_rd(6'h10, d); chk("R6 clear", d, 0);
    // R8 aborted and lone stop keys
    bus_wr(6'h1C, 16'hACED);
    bus_wr(6'h08, 16'h2BAD); bus_wr(6'h00, 16'h0000); bus_wr(6'h0C, 16'hCAFE);
    bus_rd(6'h0C, d); chk("R8 interrupted", d, 0);
    bus_wr(6'h0C, 16'hCAFE); bus_rd(6'h0C, d); chk("R8 lone key", d, 0);
    bus_wr(6'h08, 16'h2BAD); bus_wr(6'h0C, 16'hCAFE);
    bus_rd(6'h0C, d); chk("R7 stopped", d, 16'hDABE);
    // R13 debug
    bus_wr(6'h1C, 16'hACED); dbg_mode = 1'b1;
    do_tick(r); rd_count(c); chk("R13 stalled", c, DEF_TO);
    bus_rd(6'h18, d); chk("R13 mode bit", d, 2);
    bus_wr(6'h18, 16'h0001); bus_rd(6'h18, d); chk("R13 override bit", d, 3);
    do_tick(r); rd_count(c); chk("R13 override counts", c, DEF_TO - 1);
    dbg_mode = 1'b0;

    // random phase against the bench model
    bus_wr(6'h04, 16'd7); bus_wr(6'h00, 16'hFEED);
    exp_to = 7; exp_cnt = 7;
    for (int k = 0; k < 300; k++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin bus_wr(6'h00, 16'hFEED); exp_cnt = exp_to; end
        1: begin
             d = 16'($urandom);
             if (d == 16'hFEED) d = 16'h0;
             bus_wr(6'h00, d);
           end
        2: begin
             exp_to = int'($urandom_range(1, 12));
             bus_wr(6'h04, 16'(exp_to));
           end
        3: begin
             do_tick(r);
             chk("R5 random fire", r, int'(model_fires(exp_cnt)));
             exp_cnt = model_next(exp_cnt, exp_to);
           end
        default: begin
             rd_count(c); chk("R4 random count", c, exp_cnt);
           end
      endcase
    end
    rd_count(c); chk("R2 final count", c, exp_cnt);

    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    bus_rd(6'h10, d); chk("R6 por clears", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule